// File: doc/BRIEF.md
# Scoped Fence Readiness Tracker

This block decides when a memory fence may issue in a core that decodes in order and completes out of order. Software brackets code regions with scope-open and scope-close markers. The block keeps the nesting depth of these regions and marks each memory operation at decode with a tag vector. The tag has one bit for each nesting level that is open at that moment, plus one shared bit for accesses that software has flagged as part of a fence's variable set. Tags are held per slot in two circular structures: an 8-slot reorder tracker, whose operations complete in any order and retire from the head, and an 8-slot store queue, which drains from the head.

When a fence is decoded, the block records its kind and the bit it must watch, and takes a snapshot of which slots are older than the fence. A scoped fence waits only for older operations whose tag has the bit of the innermost open level. A set fence waits only for older operations carrying the set bit. A global fence waits for every older reorder operation to complete and every older queued store to drain. The ready output is combinational from the stored slot state. Operations that are unscoped or younger than the fence never hold back a scoped fence.

Top module: `scoped_fence_tracker`

## Requirements
- R1: `scope_start` raises `scope_depth` by one and `scope_end` lowers it by one, visible on the cycle after the strobe. When both are strobed together the depth is unchanged.
- R2: A `scope_start` at the maximum depth (default 4), or a `scope_end` at depth 0, leaves the depth unchanged and sets `scope_err`. `scope_err` stays set until reset.
- R3: An operation allocated while the depth is d gets tag bits 0..d-1 set, with bit k standing for nesting level k+1. So an operation inside an inner scope also carries the bits of all enclosing scopes.
- R4: A scoped fence (`fence_kind` = 1) decoded at depth d>0 watches tag bit d-1. `fence_ready` is high once no older reorder slot that is still incomplete, and no older undrained store slot, has that bit.
- R5: Operations allocated in the same cycle as the fence decode, or later, are younger and never hold `fence_ready` low.
- R6: A global fence (`fence_kind` = 0 or 3) is ready only when every older reorder slot has completed and every older store slot has drained.
- R7: An allocation with its set flag high also sets tag bit 4 (the bit above the level bits). A set fence (`fence_kind` = 2) watches only that bit.
- R8: An older store with no scope bits that has not drained (for example, a cache miss) does not hold a scoped fence low.
- R9: The watched bit is fixed when the fence is decoded. A later `scope_end` or `scope_start` does not change it.
- R10: A scoped fence decoded at depth 0 behaves as a global fence.
- R11: `fence_ready` is low while no fence is pending. `fence_issue` clears the pending fence. A new `fence_dec` replaces a pending fence and takes priority over a `fence_issue` in the same cycle. Completing a reorder slot clears its tag.
- R12: An allocation into a full structure is ignored. A retire is ignored unless the head slot has completed, and a drain of an empty queue is ignored. Reorder slots are numbered 0..7 in allocation order, wrapping around, and `rob_cmp_idx` names a slot by that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scope_start | input | 1 | Open a nested fence scope |
| scope_end | input | 1 | Close the innermost fence scope |
| rob_alloc | input | 1 | Allocate a memory operation into the reorder tracker |
| rob_alloc_set | input | 1 | The allocated operation belongs to the flagged variable set |
| rob_cmp | input | 1 | Mark a reorder slot complete |
| rob_cmp_idx | input | 3 | Slot number to complete |
| rob_retire | input | 1 | Retire the head reorder slot |
| sb_alloc | input | 1 | Allocate a store into the store queue |
| sb_alloc_set | input | 1 | The store belongs to the flagged variable set |
| sb_drain | input | 1 | Drain the head store |
| fence_dec | input | 1 | A fence is decoded this cycle |
| fence_kind | input | 2 | 0 global, 1 scoped, 2 set, 3 global |
| fence_issue | input | 1 | The pending fence has issued |
| fence_ready | output | 1 | The pending fence may issue |
| scope_depth | output | 3 | Number of open scopes |
| scope_err | output | 1 | Sticky push-overflow or pop-underflow flag |

## Verification
Every strobe is registered once, so its effect on `scope_depth`, `scope_err` and the stored slot state appears in the cycle after the edge that samples it. `fence_ready` follows that state with no further delay. The bench applies the same strobes to a queue-based model just before each rising edge and compares all three outputs at the next falling edge, so each result is checked in the first cycle it is due. The directed phases set up one situation at a time: nested tags, a fixed watched level, an unscoped missing store, younger operations, set tagging, a global drain, and full structures. A random phase then mixes all the strobes together.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    FK_GLOBAL = 2'd0,
    FK_SCOPED = 2'd1,
    FK_SET    = 2'd2,
    FK_GLOB2  = 2'd3
  } fence_kind_e;
endpackage

// File: rtl/fsc_scope_stack.sv
module fsc_scope_stack #(
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [DW-1:0]    depth,
  output logic             err,
  output logic [DEPTH-1:0] open_mask,
  output logic [DEPTH-1:0] top_sel
);
  logic [DW-1:0] depth_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else if (push && !pop) begin
      if (depth_q == DW'(DEPTH)) err_q <= 1'b1;
      else depth_q <= depth_q + 1'b1;
    end else if (pop && !push) begin
      if (depth_q == '0) err_q <= 1'b1;
      else depth_q <= depth_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    assign open_mask[i] = DW'(i) < depth_q;
    assign top_sel[i]   = depth_q == DW'(i + 1);
  end

  assign depth = depth_q;
  assign err   = err_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DW'(DEPTH)); // R1
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    push && pop |=> $stable(depth_q)); // R1
  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    push && !pop && depth_q == DW'(DEPTH) |=> err_q && depth_q == DW'(DEPTH)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R2
endmodule

// File: rtl/fsc_tag_buf.sv
module fsc_tag_buf #(
  parameter int N       = 8,
  parameter int W       = 5,
  parameter bit HAS_CMP = 1'b1,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic [W-1:0]  alloc_tag,
  input  logic          cmp,
  input  logic [AW-1:0] cmp_idx,
  input  logic          free,
  input  logic          snap,
  input  logic [W-1:0]  chk_sel,
  input  logic          chk_all,
  output logic          hit,
  output logic          older_pend
);
  logic [N-1:0]  valid_q, done_q, older_q;
  logic [W-1:0]  tag_q [N];
  logic [AW-1:0] head_q, tail_q;
  logic [AW:0]   cnt_q;
  logic          free_ok, alloc_ok, cmp_ok;

  assign free_ok  = free && valid_q[head_q] && (!HAS_CMP || done_q[head_q]);
  assign alloc_ok = alloc && (cnt_q != (AW+1)'(N));
  assign cmp_ok   = HAS_CMP && cmp && valid_q[cmp_idx] && !done_q[cmp_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      done_q  <= '0;
      older_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < N; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (snap) older_q[i] <= valid_q[i] && !(free_ok && head_q == AW'(i));
        if (free_ok && head_q == AW'(i)) begin
          valid_q[i] <= 1'b0;
          done_q[i]  <= 1'b0;
          older_q[i] <= 1'b0;
          tag_q[i]   <= '0;
        end else if (cmp_ok && cmp_idx == AW'(i)) begin
          done_q[i] <= 1'b1;
          tag_q[i]  <= '0;
        end
        if (alloc_ok && tail_q == AW'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          older_q[i] <= 1'b0;
          tag_q[i]   <= alloc_tag;
        end
      end
      if (free_ok)  head_q <= (head_q == AW'(N-1)) ? '0 : head_q + 1'b1;
      if (alloc_ok) tail_q <= (tail_q == AW'(N-1)) ? '0 : tail_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(alloc_ok) - (AW+1)'(free_ok);
    end
  end

  always_comb begin
    hit        = 1'b0;
    older_pend = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (older_q[i] && valid_q[i] && !done_q[i]) begin
        older_pend = 1'b1;
        if (chk_all || |(tag_q[i] & chk_sel)) hit = 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (AW+1)'(N)); // R12
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    cnt_q == (AW+1)'(N) && alloc && !free_ok |=> cnt_q == (AW+1)'(N)); // R12
  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_OLDER_LIVE: assert property (@(posedge clk) disable iff (rst)
      older_q[i] |-> valid_q[i]); // R5
  end
endmodule

// File: rtl/fsc_fence_ctl.sv
module fsc_fence_ctl
  import fsc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int W = DEPTH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec,
  input  logic [1:0]       kind,
  input  logic             issue,
  input  logic [DEPTH-1:0] top_sel,
  input  logic             depth_zero,
  output logic             pend,
  output logic             glob,
  output logic [W-1:0]     sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      glob <= 1'b0;
      sel  <= '0;
    end else if (dec) begin
      pend <= 1'b1;
      case (fence_kind_e'(kind))
        FK_SCOPED: begin
          glob <= depth_zero;
          sel  <= depth_zero ? '0 : {1'b0, top_sel};
        end
        FK_SET: begin
          glob <= 1'b0;
          sel  <= {1'b1, {DEPTH{1'b0}}};
        end
        default: begin
          glob <= 1'b1;
          sel  <= '0;
        end
      endcase
    end else if (issue) begin
      pend <= 1'b0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    pend |-> $onehot0(sel)); // R4
  AST_DEC_PEND: assert property (@(posedge clk) disable iff (rst)
    dec |=> pend); // R11
endmodule

// File: rtl/scoped_fence_tracker.sv
module scoped_fence_tracker #(
  parameter int DEPTH = 4,
  parameter int ROB_N = 8,
  parameter int SB_N  = 8,
  localparam int W   = DEPTH + 1,
  localparam int RAW = $clog2(ROB_N),
  localparam int SAW = $clog2(SB_N),
  localparam int DW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scope_start,
  input  logic           scope_end,
  input  logic           rob_alloc,
  input  logic           rob_alloc_set,
  input  logic           rob_cmp,
  input  logic [RAW-1:0] rob_cmp_idx,
  input  logic           rob_retire,
  input  logic           sb_alloc,
  input  logic           sb_alloc_set,
  input  logic           sb_drain,
  input  logic           fence_dec,
  input  logic [1:0]     fence_kind,
  input  logic           fence_issue,
  output logic           fence_ready,
  output logic [DW-1:0]  scope_depth,
  output logic           scope_err
);
  logic [DEPTH-1:0] open_mask, top_sel;
  logic             pend, glob;
  logic [W-1:0]     sel, rob_tag, sb_tag;
  logic             rob_hit, sb_hit, rob_opend, sb_opend;

  fsc_scope_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(scope_start), .pop(scope_end),
    .depth(scope_depth), .err(scope_err),
    .open_mask(open_mask), .top_sel(top_sel)
  );

  assign rob_tag = {rob_alloc_set, open_mask};
  assign sb_tag  = {sb_alloc_set, open_mask};

  fsc_fence_ctl #(.DEPTH(DEPTH)) u_fence (
    .clk(clk), .rst(rst), .dec(fence_dec), .kind(fence_kind),
    .issue(fence_issue), .top_sel(top_sel),
    .depth_zero(scope_depth == '0),
    .pend(pend), .glob(glob), .sel(sel)
  );

  fsc_tag_buf #(.N(ROB_N), .W(W), .HAS_CMP(1'b1)) u_rob (
    .clk(clk), .rst(rst), .alloc(rob_alloc), .alloc_tag(rob_tag),
    .cmp(rob_cmp), .cmp_idx(rob_cmp_idx), .free(rob_retire),
    .snap(fence_dec), .chk_sel(sel), .chk_all(glob),
    .hit(rob_hit), .older_pend(rob_opend)
  );

  fsc_tag_buf #(.N(SB_N), .W(W), .HAS_CMP(1'b0)) u_sb (
    .clk(clk), .rst(rst), .alloc(sb_alloc), .alloc_tag(sb_tag),
    .cmp(1'b0), .cmp_idx({SAW{1'b0}}), .free(sb_drain),
    .snap(fence_dec), .chk_sel(sel), .chk_all(glob),
    .hit(sb_hit), .older_pend(sb_opend)
  );

  assign fence_ready = pend && !rob_hit && !sb_hit;

  AST_GLOBAL_DRAINED: assert property (@(posedge clk) disable iff (rst)
    fence_ready && glob |-> !rob_opend && !sb_opend); // R6
  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    fence_issue && !fence_dec |=> !fence_ready); // R11
endmodule

// File: tb/tb_scoped_fence_tracker.sv
module tb_scoped_fence_tracker;
  localparam int D = 4;
  localparam int W = D + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic scope_start = 0, scope_end = 0, rob_alloc = 0, rob_alloc_set = 0;
  logic rob_cmp = 0, rob_retire = 0, sb_alloc = 0, sb_alloc_set = 0, sb_drain = 0;
  logic [2:0] rob_cmp_idx = '0;
  logic fence_dec = 0, fence_issue = 0;
  logic [1:0] fence_kind = '0;
  logic fence_ready, scope_err;
  logic [2:0] scope_depth;

  always #4 clk = ~clk;

  scoped_fence_tracker dut (
    .clk(clk), .rst(rst), .scope_start(scope_start), .scope_end(scope_end),
    .rob_alloc(rob_alloc), .rob_alloc_set(rob_alloc_set), .rob_cmp(rob_cmp),
    .rob_cmp_idx(rob_cmp_idx), .rob_retire(rob_retire), .sb_alloc(sb_alloc),
    .sb_alloc_set(sb_alloc_set), .sb_drain(sb_drain), .fence_dec(fence_dec),
    .fence_kind(fence_kind), .fence_issue(fence_issue),
    .fence_ready(fence_ready), .scope_depth(scope_depth), .scope_err(scope_err)
  );

  typedef struct { int slot; bit [W-1:0] tag; bit done; bit old; } ent_t;
  ent_t rob_q[$];
  ent_t sb_q[$];
  int  m_depth = 0, rob_tail = 0, n_checks = 0, n_fail = 0;
  bit  m_err = 0, m_pend = 0, m_glob = 0, finished = 0;
  bit [W-1:0] m_sel = '0;
  string cur_req = "R1";

  function automatic bit [W-1:0] open_bits(int d, bit s);
    bit [W-1:0] t = '0;
    for (int k = 0; k < d; k++) t[k] = 1'b1;
    t[D] = s;
    return t;
  endfunction

  function automatic bit exp_ready();
    if (!m_pend) return 0;
    foreach (rob_q[i])
      if (rob_q[i].old && !rob_q[i].done && (m_glob || (rob_q[i].tag & m_sel) != 0)) return 0;
    foreach (sb_q[i])
      if (sb_q[i].old && (m_glob || (sb_q[i].tag & m_sel) != 0)) return 0;
    return 1;
  endfunction

  task automatic model_step();
    bit rob_full = (rob_q.size() == 8);
    bit sb_full  = (sb_q.size() == 8);
    if (rob_retire && rob_q.size() > 0 && rob_q[0].done) void'(rob_q.pop_front());
    if (sb_drain && sb_q.size() > 0) void'(sb_q.pop_front());
    if (rob_cmp)
      foreach (rob_q[i])
        if (rob_q[i].slot == int'(rob_cmp_idx) && !rob_q[i].done) begin
          rob_q[i].done = 1; rob_q[i].tag = '0;
        end
    if (fence_dec) begin
      foreach (rob_q[i]) rob_q[i].old = 1;
      foreach (sb_q[i]) sb_q[i].old = 1;
      m_pend = 1;
      if (fence_kind == 2'd1 && m_depth > 0) begin
        m_glob = 0; m_sel = '0; m_sel[m_depth-1] = 1'b1;
      end else if (fence_kind == 2'd2) begin
        m_glob = 0; m_sel = '0; m_sel[D] = 1'b1;
      end else begin
        m_glob = 1; m_sel = '0;
      end
    end else if (fence_issue) m_pend = 0;
    if (rob_alloc && !rob_full) begin
      rob_q.push_back('{slot: rob_tail, tag: open_bits(m_depth, rob_alloc_set), done: 0, old: 0});
      rob_tail = (rob_tail + 1) % 8;
    end
    if (sb_alloc && !sb_full)
      sb_q.push_back('{slot: 0, tag: open_bits(m_depth, sb_alloc_set), done: 0, old: 0});
    if (scope_start && !scope_end) begin
      if (m_depth == D) m_err = 1; else m_depth++;
    end else if (scope_end && !scope_start) begin
      if (m_depth == 0) m_err = 1; else m_depth--;
    end
  endtask

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check("fence_ready", int'(fence_ready), int'(exp_ready()));
    check("scope_depth", int'(scope_depth), m_depth);
    check("scope_err", int'(scope_err), int'(m_err));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    {scope_start, scope_end, rob_alloc, rob_alloc_set, rob_cmp, rob_retire} = '0;
    {sb_alloc, sb_alloc_set, sb_drain, fence_dec, fence_issue} = '0;
    compare();
  endtask

  int rob_slot_of_last;

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R11"; compare();   // reset state: depth 0, no error, not ready

    // R3 / R4: nested tags; outer-level bit set on inner op
    cur_req = "R1"; scope_start = 1; tick(); scope_start = 1; tick();
    cur_req = "R3"; rob_alloc = 1; tick();                 // slot 0 tag 0011
    scope_end = 1; tick();
    rob_alloc = 1; tick();                                 // slot 1 tag 0001
    cur_req = "R4"; fence_dec = 1; fence_kind = 2'd1; tick(); // watches bit0
    check("scoped fence blocked by inner op", int'(fence_ready), 0);
    rob_cmp = 1; rob_cmp_idx = 3'd0; tick();
    check("still blocked by slot1", int'(fence_ready), 0);
    rob_cmp = 1; rob_cmp_idx = 3'd1; tick();
    check("ready after both done", int'(fence_ready), 1);
    cur_req = "R11"; fence_issue = 1; tick();
    check("issue clears", int'(fence_ready), 0);
    rob_retire = 1; tick(); rob_retire = 1; tick();

    // R9: captured level stays fixed
    cur_req = "R9"; rob_alloc = 1; tick();                 // slot 2 tag 0001
    scope_start = 1; tick();                               // depth 2
    fence_dec = 1; fence_kind = 2'd1; tick();              // watches bit1
    check("level1 op does not block level2 fence", int'(fence_ready), 1);
    scope_end = 1; tick();
    check("scope_end keeps watched level", int'(fence_ready), 1);
    rob_cmp = 1; rob_cmp_idx = 3'd2; tick(); rob_retire = 1; tick();

    // R8: unscoped missing store
    cur_req = "R8"; sb_alloc = 1; tick();                  // tag 0001
    scope_end = 1; tick();                                 // depth 0
    sb_alloc = 1; tick();                                  // unscoped store
    scope_start = 1; tick();                               // depth 1
    fence_dec = 1; fence_kind = 2'd1; tick();
    check("scoped store blocks", int'(fence_ready), 0);
    sb_drain = 1; tick();
    check("unscoped miss store does not block", int'(fence_ready), 1);

    // R6: global waits for drain
    cur_req = "R6"; fence_dec = 1; fence_kind = 2'd0; tick();
    check("global blocked by store", int'(fence_ready), 0);
    sb_drain = 1; tick();
    check("global ready after drain", int'(fence_ready), 1);

    // R5: younger ops in same cycle as fence
    cur_req = "R5"; fence_dec = 1; fence_kind = 2'd1; rob_alloc = 1; sb_alloc = 1; tick();
    check("younger ops ignored", int'(fence_ready), 1);
    rob_alloc = 1; tick();
    check("later op ignored", int'(fence_ready), 1);
    rob_cmp = 1; rob_cmp_idx = 3'd3; tick(); rob_cmp = 1; rob_cmp_idx = 3'd4; tick();
    rob_retire = 1; tick(); rob_retire = 1; tick(); sb_drain = 1; tick();

    // R7: set scope
    cur_req = "R7"; rob_alloc = 1; rob_alloc_set = 1; tick(); // slot 5
    rob_alloc = 1; tick();                                    // slot 6, scoped only
    fence_dec = 1; fence_kind = 2'd2; tick();
    check("set fence blocked by set op", int'(fence_ready), 0);
    rob_cmp = 1; rob_cmp_idx = 3'd5; tick();
    check("set fence ignores scoped op", int'(fence_ready), 1);
    rob_cmp = 1; rob_cmp_idx = 3'd6; tick();
    rob_retire = 1; tick(); rob_retire = 1; tick();

    // R10: scoped fence at depth 0
    cur_req = "R10"; scope_end = 1; tick();
    rob_alloc = 1; tick();                                    // slot 7 unscoped
    fence_dec = 1; fence_kind = 2'd1; tick();
    check("depth0 scoped acts global", int'(fence_ready), 0);
    rob_cmp = 1; rob_cmp_idx = 3'd7; tick();
    check("ready once complete", int'(fence_ready), 1);
    rob_retire = 1; tick();

    // R2: underflow and overflow
    cur_req = "R2"; scope_end = 1; tick();
    check("underflow err", int'(scope_err), 1);
    for (int i = 0; i < 5; i++) begin scope_start = 1; tick(); end
    check("depth saturates", int'(scope_depth), 4);
    cur_req = "R1"; scope_start = 1; scope_end = 1; tick();
    for (int i = 0; i < 4; i++) begin scope_end = 1; tick(); end

    // R12: full tracker, incomplete head retire
    cur_req = "R12";
    for (int i = 0; i < 9; i++) begin rob_alloc = 1; tick(); end
    fence_dec = 1; fence_kind = 2'd0; tick();
    rob_retire = 1; tick();
    check("incomplete head stays", int'(fence_ready), 0);
    for (int i = 0; i < 8; i++) begin rob_cmp = 1; rob_cmp_idx = 3'(i); tick(); end
    check("global ready after all complete", int'(fence_ready), 1);
    for (int i = 0; i < 8; i++) begin rob_retire = 1; tick(); end

    // random mix
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      scope_start   = ($urandom % 6) == 0;
      scope_end     = ($urandom % 6) == 0;
      rob_alloc     = ($urandom % 3) == 0;
      rob_alloc_set = $urandom % 2;
      rob_cmp       = ($urandom % 2) == 0;
      rob_cmp_idx   = 3'($urandom);
      rob_retire    = ($urandom % 3) == 0;
      sb_alloc      = ($urandom % 4) == 0;
      sb_alloc_set  = $urandom % 2;
      sb_drain      = ($urandom % 4) == 0;
      fence_dec     = ($urandom % 10) == 0;
      fence_kind    = 2'($urandom);
      fence_issue   = ($urandom % 5) == 0;
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule